// File: doc/BRIEF.md
# Fully Associative LRU Tag Store with Nested-Size Statistics

This block holds the tags of a small, fully associative cache and replaces by true least-recently-used order. Every entry carries a valid bit and an age rank. Rank 0 is the most recently used entry and rank ENTRIES-1 is the least recently used one. A lookup compares the block-aligned address against all entries in the same cycle and returns the hit and the entry index. The caller chooses per lookup whether the access refreshes recency or only probes. An insert places a new tag into the entry chosen for replacement. An invalidate clears one entry by index.

Because the age rank of a hit is its depth in the LRU stack, one access gives the outcome for every smaller power-of-two cache built from the same stack. Level j has BASE·2^j entries, and the top level is the full capacity. The block reports a residency mask with one bit per smaller size. It keeps a hit counter and a miss counter for each level and a total access counter. Only recency-updating lookups count as accesses. Data storage and write-back handling sit outside this block.

Top module: `fa_lru_tags`

## Requirements
- R1: The tag is the address with its low OFF_W bits dropped. Two addresses that differ only in those bits match the same entry, and a difference in any higher bit makes them different tags.
- R2: `hit` and `hitIdx` are combinational and valid in the same cycle as `lookupValid`. `hit` is 0 whenever `lookupValid` is 0.
- R3: A lookup with `lookupTouch`=1 that hits at rank r moves that entry to rank 0. Every entry with rank below r ages by one, and all other ranks stay unchanged.
- R4: A lookup with `lookupTouch`=0 changes neither the recency order nor any counter.
- R5: Bit k of `inMask` is 1 exactly when the lookup hits an entry whose rank is below BASE·2^k. On a miss the mask is all zero.
- R6: On a touching lookup, `accessCount` increments by one. For each level j, a hit of rank below BASE·2^j increments that level's hit counter. A deeper hit, or a tag miss, increments that level's miss counter. Level j occupies bits [j·CNT_W +: CNT_W] of `hitCount` and `missCount`, and the top level j=NUM_SIZES covers the full capacity.
- R7: `victimIdx` is the lowest-index invalid entry if one exists. Otherwise it is the entry of rank ENTRIES-1.
- R8: An insert writes the tag into `victimIdx`, marks that entry valid and makes it rank 0, with the other ranks aging as in R3.
- R9: An invalidate clears the valid bit of `invalIdx`. That entry then misses and becomes eligible as victim under R7.
- R10: After reset all entries are invalid, each rank equals its entry index, every counter reads zero and `victimIdx` is 0.
- R11: At most one request is served per cycle, in the priority order lookup, insert, invalidate. A request that loses the priority has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request |
| lookupTouch | input | 1 | 1: update recency and statistics; 0: probe only |
| lookupAddr | input | ADDR_W | Lookup address |
| insertValid | input | 1 | Insert request |
| insertAddr | input | ADDR_W | Address whose tag is inserted |
| invalValid | input | 1 | Invalidate request |
| invalIdx | input | log2(ENTRIES) | Entry to invalidate |
| hit | output | 1 | Lookup matched a valid entry |
| hitIdx | output | log2(ENTRIES) | Index of matching entry |
| inMask | output | NUM_SIZES | Residency per smaller cache size |
| victimIdx | output | log2(ENTRIES) | Entry chosen for replacement |
| hitCount | output | (NUM_SIZES+1)·CNT_W | Hit counter per level |
| missCount | output | (NUM_SIZES+1)·CNT_W | Miss counter per level |
| accessCount | output | CNT_W | Touching lookup count |

## Verification
On every cycle the assertions check four things. `hit` never appears without a lookup. The residency mask is nested and implies a hit. Each level's hit and miss counters sum to the access count. The access counter moves by exactly one on touching lookups and holds on probes. Only the directed scenarios can show that the recency order ages correctly, since it appears only through the order in which victims are chosen. The same holds for the depth each hit is credited with, for invalid entries being preferred as victims, and for requests that lose arbitration having no effect.

// File: rtl/fa_lru_pkg.sv
package fa_lru_pkg;

  // Strobes from control to the entry datapath and statistics.
  typedef struct packed {
    logic promote;     // move targetIdx to rank 0
    logic writeTag;    // load tag into targetIdx, set valid
    logic clearValid;  // clear valid of targetIdx
    logic countAccess; // update statistics counters
  } ctrlStrobe_t;

endpackage

// File: rtl/fa_lru_ctrl.sv
module fa_lru_ctrl
  import fa_lru_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             lookupValid,
  input  logic             lookupTouch,
  input  logic             insertValid,
  input  logic             invalValid,
  input  logic [IDX_W-1:0] invalIdx,
  input  logic             hit,
  input  logic [IDX_W-1:0] hitIdx,
  input  logic [IDX_W-1:0] victimIdx,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] targetIdx
);

  // Fixed priority: lookup, then insert, then invalidate.
  always_comb begin
    strobe    = '0;
    targetIdx = '0;
    if (lookupValid) begin
      strobe.countAccess = lookupTouch;
      strobe.promote     = lookupTouch && hit;
      targetIdx          = hitIdx;
    end else if (insertValid) begin
      strobe.writeTag = 1'b1;
      strobe.promote  = 1'b1;
      targetIdx       = victimIdx;
    end else if (invalValid) begin
      strobe.clearValid = 1'b1;
      targetIdx         = invalIdx;
    end
  end

endmodule

// File: rtl/fa_lru_datapath.sv
module fa_lru_datapath
  import fa_lru_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int BASE      = 2,
  parameter int TAG_W     = 14,
  parameter int IDX_W     = $clog2(ENTRIES),
  parameter int NUM_SIZES = $clog2(ENTRIES / BASE)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lookupEn,
  input  logic [TAG_W-1:0]     lookupTag,
  input  logic [TAG_W-1:0]     insertTag,
  input  ctrlStrobe_t          strobe,
  input  logic [IDX_W-1:0]     targetIdx,
  output logic                 hit,
  output logic [IDX_W-1:0]     hitIdx,
  output logic [IDX_W-1:0]     hitRank,
  output logic [IDX_W-1:0]     victimIdx,
  output logic [NUM_SIZES-1:0] inMask
);

  localparam logic [IDX_W-1:0] LRU_RANK = IDX_W'(ENTRIES - 1);

  logic [TAG_W-1:0] tagQ  [ENTRIES];
  logic [IDX_W-1:0] rankQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0] promRank;
  logic anyMatch;
  logic freeFound;

  // Parallel tag compare.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign matchVec[i] = validQ[i] && (tagQ[i] == lookupTag);
  end

  always_comb begin
    anyMatch = 1'b0;
    hitIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        hitIdx   = IDX_W'(i);
      end
    end
  end

  assign hit     = lookupEn && anyMatch;
  assign hitRank = rankQ[hitIdx];

  // Victim: lowest invalid entry, else the oldest entry.
  always_comb begin
    freeFound = 1'b0;
    victimIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeFound = 1'b1;
        victimIdx = IDX_W'(i);
      end
    end
    if (!freeFound) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rankQ[i] == LRU_RANK) victimIdx = IDX_W'(i);
      end
    end
  end

  // Residency per nested size.
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_mask
    localparam int SIZE_K = BASE << k;
    assign inMask[k] = hit && (int'(hitRank) < SIZE_K);
  end

  assign promRank = rankQ[targetIdx];

  // Rank and tag state.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rankQ[i]  <= IDX_W'(i);
        tagQ[i]   <= '0;
        validQ[i] <= 1'b0;
      end else begin
        if (strobe.promote) begin
          if (targetIdx == IDX_W'(i))  rankQ[i] <= '0;
          else if (rankQ[i] < promRank) rankQ[i] <= rankQ[i] + 1'b1;
        end
        if (strobe.writeTag && targetIdx == IDX_W'(i)) begin
          tagQ[i]   <= insertTag;
          validQ[i] <= 1'b1;
        end
        if (strobe.clearValid && targetIdx == IDX_W'(i)) validQ[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fa_lru_stats.sv
module fa_lru_stats #(
  parameter int BASE       = 2,
  parameter int IDX_W      = 3,
  parameter int NUM_LEVELS = 3,
  parameter int CNT_W      = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        countAccess,
  input  logic                        hit,
  input  logic [IDX_W-1:0]            hitRank,
  output logic [NUM_LEVELS*CNT_W-1:0] hitCount,
  output logic [NUM_LEVELS*CNT_W-1:0] missCount,
  output logic [CNT_W-1:0]            accessCount
);

  logic [CNT_W-1:0] accQ;

  always_ff @(posedge clk) begin
    if (!rstN)            accQ <= '0;
    else if (countAccess) accQ <= accQ + 1'b1;
  end
  assign accessCount = accQ;

  for (genvar j = 0; j < NUM_LEVELS; j++) begin : g_level
    localparam int LEVEL_SIZE = BASE << j;
    logic [CNT_W-1:0] hitQ, missQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hitQ  <= '0;
        missQ <= '0;
      end else if (countAccess) begin
        if (hit && int'(hitRank) < LEVEL_SIZE) hitQ  <= hitQ + 1'b1;
        else                                   missQ <= missQ + 1'b1;
      end
    end
    assign hitCount[j*CNT_W +: CNT_W]  = hitQ;
    assign missCount[j*CNT_W +: CNT_W] = missQ;
  end

endmodule

// File: rtl/fa_lru_tags.sv
module fa_lru_tags
  import fa_lru_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int BASE    = 2,
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 2,
  parameter int CNT_W   = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic lookupValid,
  input  logic lookupTouch,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic insertValid,
  input  logic [ADDR_W-1:0] insertAddr,
  input  logic invalValid,
  input  logic [$clog2(ENTRIES)-1:0] invalIdx,
  output logic hit,
  output logic [$clog2(ENTRIES)-1:0] hitIdx,
  output logic [$clog2(ENTRIES/BASE)-1:0] inMask,
  output logic [$clog2(ENTRIES)-1:0] victimIdx,
  output logic [($clog2(ENTRIES/BASE)+1)*CNT_W-1:0] hitCount,
  output logic [($clog2(ENTRIES/BASE)+1)*CNT_W-1:0] missCount,
  output logic [CNT_W-1:0] accessCount
);

  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int NUM_SIZES  = $clog2(ENTRIES / BASE);
  localparam int NUM_LEVELS = NUM_SIZES + 1;
  localparam int TAG_W      = ADDR_W - OFF_W;

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] targetIdx;
  logic [IDX_W-1:0] hitRank;

  fa_lru_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .lookupValid (lookupValid),
    .lookupTouch (lookupTouch),
    .insertValid (insertValid),
    .invalValid  (invalValid),
    .invalIdx    (invalIdx),
    .hit         (hit),
    .hitIdx      (hitIdx),
    .victimIdx   (victimIdx),
    .strobe      (strobe),
    .targetIdx   (targetIdx)
  );

  fa_lru_datapath #(
    .ENTRIES(ENTRIES), .BASE(BASE), .TAG_W(TAG_W),
    .IDX_W(IDX_W), .NUM_SIZES(NUM_SIZES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .lookupEn  (lookupValid),
    .lookupTag (lookupAddr[ADDR_W-1:OFF_W]),
    .insertTag (insertAddr[ADDR_W-1:OFF_W]),
    .strobe    (strobe),
    .targetIdx (targetIdx),
    .hit       (hit),
    .hitIdx    (hitIdx),
    .hitRank   (hitRank),
    .victimIdx (victimIdx),
    .inMask    (inMask)
  );

  fa_lru_stats #(
    .BASE(BASE), .IDX_W(IDX_W), .NUM_LEVELS(NUM_LEVELS), .CNT_W(CNT_W)
  ) stats_i (
    .clk         (clk),
    .rstN        (rstN),
    .countAccess (strobe.countAccess),
    .hit         (hit),
    .hitRank     (hitRank),
    .hitCount    (hitCount),
    .missCount   (missCount),
    .accessCount (accessCount)
  );

endmodule

// File: rtl/fa_lru_tags_chk.sv
module fa_lru_tags_chk #(
  parameter int IDX_W      = 3,
  parameter int NUM_SIZES  = 2,
  parameter int CNT_W      = 16
) (
  input logic clk,
  input logic rstN,
  input logic lookupValid,
  input logic lookupTouch,
  input logic hit,
  input logic [NUM_SIZES-1:0] inMask,
  input logic [(NUM_SIZES+1)*CNT_W-1:0] hitCount,
  input logic [(NUM_SIZES+1)*CNT_W-1:0] missCount,
  input logic [CNT_W-1:0] accessCount
);

  // R2
  hit_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> lookupValid);

  // R5
  mask_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|inMask) |-> hit);

  for (genvar k = 0; k + 1 < NUM_SIZES; k++) begin : g_nest
    // R5
    mask_nested_chk: assert property (@(posedge clk) disable iff (!rstN)
      inMask[k] |-> inMask[k+1]);
  end

  // R6
  access_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupTouch) |=> accessCount == $past(accessCount) + 1'b1);

  // R4
  probe_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !lookupTouch) |=>
      ($stable(accessCount) && $stable(hitCount) && $stable(missCount)));

  for (genvar j = 0; j <= NUM_SIZES; j++) begin : g_sum
    // R6
    level_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
      CNT_W'(hitCount[j*CNT_W +: CNT_W] + missCount[j*CNT_W +: CNT_W]) == accessCount);
  end

endmodule

bind fa_lru_tags fa_lru_tags_chk #(
  .IDX_W(IDX_W), .NUM_SIZES(NUM_SIZES), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupTouch(lookupTouch),
  .hit(hit), .inMask(inMask), .hitCount(hitCount), .missCount(missCount),
  .accessCount(accessCount)
);

// File: tb/fa_lru_tags_tb.sv
module fa_lru_tags_tb_top;

  localparam int ENTRIES = 8;
  localparam int BASE    = 2;
  localparam int ADDR_W  = 16;
  localparam int OFF_W   = 2;
  localparam int CNT_W   = 16;
  localparam int IDX_W   = 3;
  localparam int NSZ     = 2;
  localparam int NLV     = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0, lookupTouch = 1'b0, insertValid = 1'b0, invalValid = 1'b0;
  logic [ADDR_W-1:0] lookupAddr = '0, insertAddr = '0;
  logic [IDX_W-1:0]  invalIdx = '0;
  logic hit;
  logic [IDX_W-1:0] hitIdx, victimIdx;
  logic [NSZ-1:0] inMask;
  logic [NLV*CNT_W-1:0] hitCount, missCount;
  logic [CNT_W-1:0] accessCount;

  int checks = 0;
  int errors = 0;

  // Reference model: stack[0] is the most recent entry.
  int  mTag [ENTRIES];
  bit  mValid [ENTRIES];
  int  mStack [ENTRIES];
  int  mHits [NLV];
  int  mMiss [NLV];
  int  mAcc;

  always #10 clk = ~clk;

  fa_lru_tags #(.ENTRIES(ENTRIES), .BASE(BASE), .ADDR_W(ADDR_W),
                .OFF_W(OFF_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupTouch(lookupTouch),
    .lookupAddr(lookupAddr), .insertValid(insertValid), .insertAddr(insertAddr),
    .invalValid(invalValid), .invalIdx(invalIdx), .hit(hit), .hitIdx(hitIdx),
    .inMask(inMask), .victimIdx(victimIdx), .hitCount(hitCount),
    .missCount(missCount), .accessCount(accessCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mFind(input int addr);
    for (int i = 0; i < ENTRIES; i++)
      if (mValid[i] && mTag[i] == (addr >> OFF_W)) return i;
    return -1;
  endfunction

  function automatic int mDepth(input int idx);
    for (int p = 0; p < ENTRIES; p++) if (mStack[p] == idx) return p;
    return -1;
  endfunction

  function automatic int mVictim();
    for (int i = 0; i < ENTRIES; i++) if (!mValid[i]) return i;
    return mStack[ENTRIES-1];
  endfunction

  task automatic mPromote(input int idx);
    int d;
    d = mDepth(idx);
    for (int p = d; p > 0; p--) mStack[p] = mStack[p-1];
    mStack[0] = idx;
  endtask

  task automatic checkState(input string req);
    check(int'(victimIdx) == mVictim(), req, "victimIdx", victimIdx, mVictim());
    check(int'(accessCount) == mAcc, req, "accessCount", accessCount, mAcc);
    for (int j = 0; j < NLV; j++) begin
      check(int'(hitCount[j*CNT_W +: CNT_W]) == mHits[j], req, $sformatf("hitCount[%0d]", j),
            hitCount[j*CNT_W +: CNT_W], mHits[j]);
      check(int'(missCount[j*CNT_W +: CNT_W]) == mMiss[j], req, $sformatf("missCount[%0d]", j),
            missCount[j*CNT_W +: CNT_W], mMiss[j]);
    end
  endtask

  task automatic doLookup(input int addr, input bit touch, input string req);
    int idx, d, expMask;
    @(negedge clk);
    lookupValid = 1'b1; lookupTouch = touch; lookupAddr = ADDR_W'(addr);
    #2;
    idx = mFind(addr);
    d = (idx >= 0) ? mDepth(idx) : ENTRIES;
    check(hit == (idx >= 0), req, "hit", hit, idx >= 0);
    if (idx >= 0) check(int'(hitIdx) == idx, req, "hitIdx", hitIdx, idx);
    expMask = 0;
    for (int k = 0; k < NSZ; k++) if (idx >= 0 && d < (BASE << k)) expMask |= (1 << k);
    check(int'(inMask) == expMask, req, "inMask", inMask, expMask);
    if (touch) begin
      mAcc++;
      for (int j = 0; j < NLV; j++)
        if (idx >= 0 && d < (BASE << j)) mHits[j]++; else mMiss[j]++;
      if (idx >= 0) mPromote(idx);
    end
    @(negedge clk);
    lookupValid = 1'b0; lookupTouch = 1'b0;
    #2;
    checkState(req);
  endtask

  task automatic doInsert(input int addr, input string req);
    int v;
    @(negedge clk);
    insertValid = 1'b1; insertAddr = ADDR_W'(addr);
    #2;
    v = mVictim();
    check(int'(victimIdx) == v, req, "victim before insert", victimIdx, v);
    mTag[v] = addr >> OFF_W; mValid[v] = 1'b1; mPromote(v);
    @(negedge clk);
    insertValid = 1'b0;
    #2;
    checkState(req);
  endtask

  task automatic doInval(input int idx, input string req);
    @(negedge clk);
    invalValid = 1'b1; invalIdx = IDX_W'(idx);
    mValid[idx] = 1'b0;
    @(negedge clk);
    invalValid = 1'b0;
    #2;
    checkState(req);
  endtask

  // R10: state after reset
  task automatic testReset();
    #2;
    check(hit == 1'b0, "R10", "hit", hit, 0);
    checkState("R10");
  endtask

  // R7/R8: fill all entries, victims in index order, then LRU
  task automatic testFill();
    for (int i = 0; i < ENTRIES; i++) doInsert('h100 + i * 'h10, "R8");
    for (int i = 0; i < ENTRIES; i++) doLookup('h100 + i * 'h10, 1'b0, "R8");
    check(int'(victimIdx) == 0, "R7", "LRU victim after fill", victimIdx, 0);
  endtask

  // R1: offset bits ignored, higher bits compared
  task automatic testOffset();
    doLookup('h123, 1'b1, "R1");
    doLookup('h121, 1'b1, "R1");
    doLookup('h124, 1'b1, "R1");
  endtask

  // R3/R5/R6: touching hits at different depths reorder the stack
  task automatic testPromote();
    doLookup('h100, 1'b1, "R3");
    check(int'(victimIdx) == 1, "R3", "victim after LRU promoted", victimIdx, 1);
    doLookup('h170, 1'b1, "R5");
    doLookup('h140, 1'b1, "R6");
    doLookup('h110, 1'b1, "R3");
    doLookup('h150, 1'b1, "R6");
  endtask

  // R4: probe leaves order and counters untouched
  task automatic testProbe();
    int v;
    v = mVictim();
    doLookup(mTag[v] << OFF_W, 1'b0, "R4");
    check(int'(victimIdx) == v, "R4", "victim after probe", victimIdx, v);
  endtask

  // R6: tag miss is a miss at every level
  task automatic testMiss();
    doLookup('h7f0, 1'b1, "R6");
    doLookup('h7f0, 1'b1, "R5");
  endtask

  // R9/R7: invalidated entry misses and is reused first
  task automatic testInval();
    doInval(5, "R9");
    doLookup('h150, 1'b1, "R9");
    check(int'(victimIdx) == 5, "R7", "invalid entry preferred", victimIdx, 5);
    doInsert('h900, "R9");
    doLookup('h900, 1'b1, "R9");
  endtask

  // R11: lower priority requests dropped
  task automatic testPriority();
    int v;
    v = mVictim();
    @(negedge clk);
    lookupValid = 1'b1; lookupTouch = 1'b0; lookupAddr = 16'h120;
    insertValid = 1'b1; insertAddr = 16'hA00;
    @(negedge clk);
    lookupValid = 1'b0; insertValid = 1'b0;
    #2;
    check(int'(victimIdx) == v, "R11", "insert under lookup ignored", victimIdx, v);
    doLookup('hA00, 1'b0, "R11");
    @(negedge clk);
    insertValid = 1'b1; insertAddr = 16'hB00;
    invalValid = 1'b1; invalIdx = 3'd2;
    v = mVictim();
    mTag[v] = 'hB00 >> OFF_W; mValid[v] = 1'b1; mPromote(v);
    @(negedge clk);
    insertValid = 1'b0; invalValid = 1'b0;
    #2;
    checkState("R11");
    doLookup('h120, 1'b0, "R11");
    doLookup('hB00, 1'b0, "R11");
  endtask

  // R2: no hit without a lookup request
  task automatic testIdle();
    @(negedge clk);
    lookupAddr = 16'h120;
    #2;
    check(hit == 1'b0, "R2", "hit while idle", hit, 0);
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      mTag[i] = 0; mValid[i] = 1'b0; mStack[i] = i;
    end
    for (int j = 0; j < NLV; j++) begin mHits[j] = 0; mMiss[j] = 0; end
    mAcc = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFill();
    testOffset();
    testPromote();
    testProbe();
    testMiss();
    testInval();
    testPriority();
    testIdle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule